// File: doc/BRIEF.md
# Pulse-Driven Attenuation Stepper

This block keeps the gain setting of one amplifier channel as a 6-bit attenuation code. Each code step is 0.5 dB, code 0 is the highest gain and code 63 the lowest. Two active-low command lines move the code: the raise line increases gain and the lower line decreases it. A 2-bit size input picks how far each accepted pulse moves the code. Holding both lines low together for long enough returns the channel to maximum gain.

Both lines are brought into the system clock domain through a two-flop synchroniser. A per-line qualifier then measures how long the line was high before it fell and how long it stayed low. A pulse that is too short on either side is dropped. An accepted pulse changes the code once, on its release edge, and the code saturates at both ends of the range. While the channel is held (disabled), the stored code does not change, whatever arrives on the lines.

Top module: `gain_pulse_stepper`

## Requirements
- R1: After reset the attenuation code `atten` is 0 (maximum gain).
- R2: An accepted low pulse on `upN` lowers `atten` by the selected step.
- R3: An accepted low pulse on `dnN` raises `atten` by the selected step.
- R4: The step size is set by `stepSel`: 00 gives 1 code LSB, 01 gives 2, 10 gives 4 and 11 gives 12.
- R5: A step saturates: the code stops at 0 going up in gain and at 63 going down, and never wraps.
- R6: A pulse whose synchronised low time is shorter than MIN_LOW_CYC clock cycles changes nothing. A pulse exactly MIN_LOW_CYC cycles long is accepted.
- R7: A pulse that follows a high time shorter than MIN_HIGH_CYC cycles changes nothing.
- R8: When both lines are low together for RESET_CYC cycles, `atten` becomes 0 before they are released. Releasing them afterwards adds no step.
- R9: If the two lines are low together for fewer than RESET_CYC cycles, the code is not reset. A pulse on either line that overlaps the other line being low adds no step.
- R10: While `hold` is 1, `atten` keeps its value through steps and through resets.
- R11: A step takes effect only after the line returns high. While the line is still low, `atten` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| upN | input | 1 | Active-low gain-raise pulse line (asynchronous) |
| dnN | input | 1 | Active-low gain-lower pulse line (asynchronous) |
| stepSel | input | 2 | Step size select: 00=1, 01=2, 10=4, 11=12 LSB |
| hold | input | 1 | Channel disabled: freeze the stored code |
| atten | output | CODE_W | Attenuation code, 0.5 dB per LSB, 0 = maximum gain |

## Verification
Some properties are checked by assertions on every cycle: a frozen code while held, a clear that lands on zero, saturation at both ends, the direction of each accepted step, and the control strobes being mutually exclusive and a clear lasting only one cycle. The bench scenarios are needed for everything that depends on pulse timing: which widths are accepted and which rejected at the exact boundaries, the extra step that must not follow a release after reset, overlap suppression, and the code staying unchanged until release. Only whole scenarios can show these.

// File: rtl/gps_pkg.sv
package gps_pkg;
  // Strobes from the control side to the code register; at most one per cycle.
  typedef struct packed {
    logic incr;   // raise gain: lower the code
    logic decr;   // lower gain: raise the code
    logic clear;  // return to maximum gain
  } gps_cmd_t;
endpackage

// File: rtl/gps_sync.sv
module gps_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);
  // Idle level of active-low lines is high, so stages reset to ones.
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '1;
    end else begin
      stg[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign syncOut = stg[STAGES-1];
endmodule

// File: rtl/gps_line_qual.sv
module gps_line_qual #(
  parameter int MIN_HIGH_CYC = 4,
  parameter int MIN_LOW_CYC  = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic qualRise
);
  localparam int HCW = $clog2(MIN_HIGH_CYC + 1);
  localparam int LCW = $clog2(MIN_LOW_CYC + 1);
  localparam logic [HCW-1:0] HIGH_LIM = HCW'(MIN_HIGH_CYC);
  localparam logic [LCW-1:0] LOW_LIM  = LCW'(MIN_LOW_CYC);

  logic           linePrev;
  logic [HCW-1:0] highCnt;
  logic [LCW-1:0] lowCnt;
  logic           armed;
  logic           fallNow;
  logic           riseNow;

  assign fallNow = linePrev & ~lineIn;
  assign riseNow = ~linePrev & lineIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      linePrev <= 1'b1;
      highCnt  <= '0;
      lowCnt   <= '0;
      armed    <= 1'b0;
    end else begin
      linePrev <= lineIn;
      if (lineIn) begin
        highCnt <= (highCnt == HIGH_LIM) ? highCnt : highCnt + 1'b1;
        lowCnt  <= '0;
      end else begin
        highCnt <= '0;
        lowCnt  <= (lowCnt == LOW_LIM) ? lowCnt : lowCnt + 1'b1;
      end
      // A pulse is armed only if the line had been high long enough.
      if (fallNow) armed <= (highCnt == HIGH_LIM);
    end
  end

  assign qualRise = riseNow & armed & (lowCnt == LOW_LIM);

  // R6: an accepted release follows a low line on the previous cycle.
  assert_qual_after_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    qualRise |-> !$past(lineIn));
endmodule

// File: rtl/gps_ctrl.sv
module gps_ctrl
  import gps_pkg::*;
#(
  parameter int MIN_HIGH_CYC = 4,
  parameter int MIN_LOW_CYC  = 4,
  parameter int RESET_CYC    = 6
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     upSync,
  input  logic     dnSync,
  output gps_cmd_t cmd
);
  localparam int RCW = $clog2(RESET_CYC + 1);
  localparam logic [RCW-1:0] RST_LAST = RCW'(RESET_CYC - 1);
  localparam logic [RCW-1:0] RST_LIM  = RCW'(RESET_CYC);

  logic [1:0]     lineVec;
  logic [1:0]     qualVec;
  logic           bothLow;
  logic           bothHigh;
  logic           overlap;
  logic [RCW-1:0] bothCnt;

  assign lineVec = {dnSync, upSync};

  for (genvar i = 0; i < 2; i++) begin : g_qual
    gps_line_qual #(
      .MIN_HIGH_CYC(MIN_HIGH_CYC),
      .MIN_LOW_CYC (MIN_LOW_CYC)
    ) qual_i (
      .clk     (clk),
      .rstN    (rstN),
      .lineIn  (lineVec[i]),
      .qualRise(qualVec[i])
    );
  end

  assign bothLow  = ~upSync & ~dnSync;
  assign bothHigh = upSync & dnSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bothCnt <= '0;
      overlap <= 1'b0;
    end else begin
      bothCnt <= bothLow ? ((bothCnt == RST_LIM) ? bothCnt : bothCnt + 1'b1) : '0;
      // Any overlap of the two lines taints both pulses until both lines are idle.
      if (bothLow)       overlap <= 1'b1;
      else if (bothHigh) overlap <= 1'b0;
    end
  end

  assign cmd.clear = bothLow & (bothCnt == RST_LAST);
  assign cmd.incr  = qualVec[0] & ~overlap;
  assign cmd.decr  = qualVec[1] & ~overlap;

  // R8: a reset strobe is a single cycle per overlap.
  assert_clear_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clear |=> !cmd.clear);
  // R9: the strobes never coincide.
  assert_strobe_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.incr, cmd.decr, cmd.clear}));
  // R11: a step only happens when the line has just come back high.
  assert_step_on_release_R11: assert property (@(posedge clk) disable iff (!rstN)
    cmd.decr |-> (dnSync && !$past(dnSync)));
endmodule

// File: rtl/gps_datapath.sv
module gps_datapath
  import gps_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter int STEP0  = 1,
  parameter int STEP1  = 2,
  parameter int STEP2  = 4,
  parameter int STEP3  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  gps_cmd_t          cmd,
  input  logic [1:0]        stepSel,
  input  logic              hold,
  output logic [CODE_W-1:0] code
);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  logic [CODE_W-1:0] stepAmt;
  logic [CODE_W-1:0] codeNext;

  always_comb begin
    unique case (stepSel)
      2'b00:   stepAmt = CODE_W'(STEP0);
      2'b01:   stepAmt = CODE_W'(STEP1);
      2'b10:   stepAmt = CODE_W'(STEP2);
      default: stepAmt = CODE_W'(STEP3);
    endcase
  end

  always_comb begin
    codeNext = code;
    if (!hold) begin
      if (cmd.clear)
        codeNext = '0;
      else if (cmd.incr)
        codeNext = (code >= stepAmt) ? code - stepAmt : '0;
      else if (cmd.decr)
        codeNext = ((CODE_MAX - code) >= stepAmt) ? code + stepAmt : CODE_MAX;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) code <= '0;
    else       code <= codeNext;
  end

  assert_hold_freeze_R10: assert property (@(posedge clk) disable iff (!rstN)
    hold |=> $stable(code));
  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.clear && !hold) |=> (code == '0));
  assert_floor_clamp_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.incr && !hold && code == '0) |=> (code == '0));
  assert_ceiling_clamp_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.decr && !hold && code == CODE_MAX) |=> (code == CODE_MAX));
  assert_up_lowers_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.incr && !hold && code != '0) |=> (code < $past(code)));
  assert_dn_raises_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.decr && !hold && code != CODE_MAX) |=> (code > $past(code)));
endmodule

// File: rtl/gain_pulse_stepper.sv
module gain_pulse_stepper
  import gps_pkg::*;
#(
  parameter int CODE_W       = 6,
  parameter int SYNC_STAGES  = 2,
  parameter int MIN_HIGH_CYC = 4,
  parameter int MIN_LOW_CYC  = 4,
  parameter int RESET_CYC    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              upN,
  input  logic              dnN,
  input  logic [1:0]        stepSel,
  input  logic              hold,
  output logic [CODE_W-1:0] atten
);
  logic [1:0] lineSync;
  gps_cmd_t   cmd;

  gps_sync #(.W(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({dnN, upN}),
    .syncOut(lineSync)
  );

  gps_ctrl #(
    .MIN_HIGH_CYC(MIN_HIGH_CYC),
    .MIN_LOW_CYC (MIN_LOW_CYC),
    .RESET_CYC   (RESET_CYC)
  ) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .upSync(lineSync[0]),
    .dnSync(lineSync[1]),
    .cmd   (cmd)
  );

  gps_datapath #(.CODE_W(CODE_W)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (cmd),
    .stepSel(stepSel),
    .hold   (hold),
    .code   (atten)
  );

  // R1: the code leaves reset at maximum gain.
  assert_reset_max_gain_R1: assert property (@(posedge clk)
    $rose(rstN) |-> (atten == '0));
endmodule

// File: tb/gain_pulse_stepper_tb.sv
module gain_pulse_stepper_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       upN = 1'b1;
  logic       dnN = 1'b1;
  logic [1:0] stepSel = 2'b00;
  logic       hold = 1'b0;
  logic [5:0] atten;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  gain_pulse_stepper dut_i (
    .clk(clk), .rstN(rstN), .upN(upN), .dnN(dnN),
    .stepSel(stepSel), .hold(hold), .atten(atten)
  );

  // {dir(1=dn line), stepSel, expected code after the pulse}
  localparam logic [8:0] VEC [10] = '{
    {1'b1, 2'b00, 6'd1},  {1'b1, 2'b01, 6'd3},  {1'b1, 2'b10, 6'd7},
    {1'b1, 2'b11, 6'd19}, {1'b0, 2'b00, 6'd18}, {1'b0, 2'b01, 6'd16},
    {1'b0, 2'b10, 6'd12}, {1'b0, 2'b11, 6'd0},  {1'b1, 2'b11, 6'd12},
    {1'b1, 2'b11, 6'd24}
  };

  task automatic check(input logic [5:0] exp, input string tag);
    total++;
    if (atten !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, atten, exp);
    end
  endtask

  task automatic drive(input bit isDn, input logic v);
    if (isDn) dnN = v; else upN = v;
  endtask

  task automatic pulse(input bit isDn, input int lowCyc);
    @(negedge clk); drive(isDn, 1'b0);
    repeat (lowCyc) @(negedge clk);
    drive(isDn, 1'b1);
    repeat (10) @(negedge clk);
  endtask

  task automatic bothLow(input int lowCyc);
    @(negedge clk); upN = 1'b0; dnN = 1'b0;
    repeat (lowCyc) @(negedge clk);
    upN = 1'b1; dnN = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (8) @(negedge clk);
    check(6'd0, "R1 reset code");

    // Table walk: R2, R3, R4
    for (int i = 0; i < 10; i++) begin
      stepSel = VEC[i][7:6];
      pulse(VEC[i][8], 6);
      check(VEC[i][5:0], VEC[i][8] ? "R3/R4 dn step" : "R2/R4 up step");
    end

    // R5 ceiling: 24 -> 36 -> 48 -> 60 -> 63 -> 63
    stepSel = 2'b11;
    pulse(1'b1, 6); check(6'd36, "R5 dn");
    pulse(1'b1, 6); check(6'd48, "R5 dn");
    pulse(1'b1, 6); check(6'd60, "R5 dn");
    pulse(1'b1, 6); check(6'd63, "R5 clamp top");
    pulse(1'b1, 6); check(6'd63, "R5 stay top");
    // R5 floor
    pulse(1'b0, 6); check(6'd51, "R5 up");
    pulse(1'b0, 6); pulse(1'b0, 6); pulse(1'b0, 6); pulse(1'b0, 6);
    check(6'd3, "R5 up chain");
    pulse(1'b0, 6); check(6'd0, "R5 clamp bottom");
    pulse(1'b0, 6); check(6'd0, "R5 stay bottom");

    // R6 low-width qualification
    stepSel = 2'b00;
    pulse(1'b1, 2); check(6'd0, "R6 low 2 rejected");
    pulse(1'b1, 3); check(6'd0, "R6 low 3 rejected");
    pulse(1'b1, 4); check(6'd1, "R6 low 4 accepted");

    // R11 no change while held low
    @(negedge clk); dnN = 1'b0;
    repeat (12) @(negedge clk);
    check(6'd1, "R11 still low");
    dnN = 1'b1;
    repeat (10) @(negedge clk);
    check(6'd2, "R11 after release");

    // R7 short high before second pulse
    @(negedge clk); dnN = 1'b0;
    repeat (6) @(negedge clk); dnN = 1'b1;
    repeat (2) @(negedge clk); dnN = 1'b0;
    repeat (6) @(negedge clk); dnN = 1'b1;
    repeat (10) @(negedge clk);
    check(6'd3, "R7 short high rejected");

    // R8 reset by both lines
    @(negedge clk); upN = 1'b0; dnN = 1'b0;
    repeat (12) @(negedge clk);
    check(6'd0, "R8 cleared while low");
    upN = 1'b1; dnN = 1'b1;
    repeat (10) @(negedge clk);
    check(6'd0, "R8 no step on release");

    // R9 short overlap
    stepSel = 2'b10; pulse(1'b1, 6);
    stepSel = 2'b00; pulse(1'b1, 6);
    check(6'd5, "R9 setup");
    bothLow(5); check(6'd5, "R9 short overlap no reset");
    @(negedge clk); upN = 1'b0;
    repeat (2) @(negedge clk); dnN = 1'b0;
    repeat (3) @(negedge clk); dnN = 1'b1;
    repeat (3) @(negedge clk); upN = 1'b1;
    repeat (10) @(negedge clk);
    check(6'd5, "R9 overlapped pulse no step");

    // R10 hold
    hold = 1'b1;
    pulse(1'b1, 6); check(6'd5, "R10 step ignored");
    bothLow(12);    check(6'd5, "R10 reset ignored");
    hold = 1'b0;
    pulse(1'b1, 6); check(6'd6, "R10 released");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule